// File: doc/BRIEF.md
# Cipher Engine Event Interrupt and DMA Request Controller

This block sits beside a block-cipher datapath and turns four engine events into host-facing signalling. The events are: the key/IV context may be rewritten, the input block buffer has drained, a finished output block waits to be read, and a result context (tag or chaining value) has been produced. Each event sets a sticky status flag. That flag stays up until the matching service action takes it down: a context write, a data write, a data read or a tag read.

The status flags drive three kinds of output. The first is one interrupt line, masked by a per-source enable register. The second is four DMA request lines, gated by enable bits held in a configuration word. The third is a set of read-only ready indications. A remap bit in the configuration word folds the result-context source onto the data-output request and interrupt, so a single DMA channel can drain both. A reset-done indication rises one cycle after reset is released.

Top module: `cryp_evt_ctrl`

## Requirements
- R1: While reset is held, the status flags, the interrupt enables, the configuration word, `irq`, `dma_req` and `reset_done` are all 0. `reset_done` reads 1 after the first clock edge following reset release.
- R2: The status flags use this encoding: bit 0 context-in, bit 1 data-in, bit 2 data-out, bit 3 context-out. A one-cycle event pulse sets its flag at the next edge. The matching service pulse clears it (`svc_ctx_wr`, `svc_din_wr`, `svc_dout_rd`, `svc_tag_rd`). If the event and the service arrive in the same cycle, the flag ends set.
- R3: `evt_ctx_out` sets status bit 3 only when `save_ctx` is 1. With `save_ctx` at 0, the pulse leaves the flag at 0.
- R4: `irq` is a registered copy of the OR over status AND enable. It goes high one edge after that term becomes true and falls one edge after it clears.
- R5: The enable register uses the status bit layout. An enable value of 0, which is the reset value, keeps a set flag off `irq`. Writing the enable takes effect at the next edge.
- R6: The DMA request enables sit at configuration bit 5 (data-in), bit 6 (data-out), bit 7 (context-in) and bit 8 (context-out). `dma_req` uses the status encoding and is high while its flag is set and its enable bit is 1, in the same cycle as the flag.
- R7: When configuration bit 9 is 1, status bit 3 drives `dma_req[2]` (gated by bit 6) and the data-out interrupt (gated by enable bit 2). In that mode `dma_req[3]` is 0, and enable bit 3 and configuration bit 8 have no effect.
- R8: `rdy_save` equals status bit 3. `rdy_ctx` equals status bit 0 but is forced to 0 while `rdy_save` is 1, so the two are never high together.
- R9: `rdy_in` reports status bit 1 (input buffer empty). `rdy_out` reports status bit 2 (output block waiting).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_ctx_in | input | 1 | Context may be rewritten (pulse) |
| evt_din | input | 1 | Input buffer drained (pulse) |
| evt_dout | input | 1 | Output block available (pulse) |
| evt_ctx_out | input | 1 | Operation finished with a result context (pulse) |
| save_ctx | input | 1 | Result context is to be saved |
| svc_ctx_wr | input | 1 | Host wrote the context |
| svc_din_wr | input | 1 | Host wrote a data block |
| svc_dout_rd | input | 1 | Host read a data block |
| svc_tag_rd | input | 1 | Host read the result context |
| irq_en_we | input | 1 | Write strobe for the enable register |
| irq_en_wd | input | 4 | Enable register write value |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wd | input | 10 | Configuration word write value |
| irq_status | output | 4 | Status flags |
| irq | output | 1 | Interrupt line |
| dma_req | output | 4 | DMA requests, status encoding |
| rdy_ctx | output | 1 | Context may be written |
| rdy_save | output | 1 | Result context available |
| rdy_in | output | 1 | Input buffer empty |
| rdy_out | output | 1 | Output block waiting |
| reset_done | output | 1 | Reset completed |

## Verification
Two functions can land in the same cycle: setting a flag by its event and clearing it by its service action. The bench provokes this by pulsing `evt_din` and `svc_din_wr` in the same cycle. It judges the result by requiring status bit 1 and `rdy_in` to stay high afterwards, so the new event is not lost. A second overlap is also exercised: the context-in flag raised while a result context is pending, with `rdy_ctx` required to stay low until the tag read.

// File: rtl/cev_pkg.sv
package cev_pkg;
   localparam int unsigned NUM_SRC = 4;

   typedef enum logic [1:0] {
      SRC_CTX_IN   = 2'd0,
      SRC_DATA_IN  = 2'd1,
      SRC_DATA_OUT = 2'd2,
      SRC_CTX_OUT  = 2'd3
   } src_e;

   typedef logic [NUM_SRC-1:0] src_vec_t;

   // offsets of the DMA enables above the configured base bit
   localparam int unsigned DMA_OFS_DIN     = 0;
   localparam int unsigned DMA_OFS_DOUT    = 1;
   localparam int unsigned DMA_OFS_CTX_IN  = 2;
   localparam int unsigned DMA_OFS_CTX_OUT = 3;
endpackage

// File: rtl/cev_flag.sv
module cev_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   generate
      if (SET_WINS) begin : g_set_pri
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flag_q <= 1'b0;
            else if (set_i)  flag_q <= 1'b1;
            else if (clr_i)  flag_q <= 1'b0;
         end
      end else begin : g_clr_pri
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flag_q <= 1'b0;
            else if (clr_i)  flag_q <= 1'b0;
            else if (set_i)  flag_q <= 1'b1;
         end
      end
   endgenerate

   assign flag_o = flag_q;
endmodule

// File: rtl/cev_regs.sv
module cev_regs #(
   parameter int unsigned NSRC  = 4,
   parameter int unsigned CFG_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_we,
   input  logic [NSRC-1:0]  en_wd,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wd,
   output logic [NSRC-1:0]  en_o,
   output logic [CFG_W-1:0] cfg_o
);
   logic [NSRC-1:0]  en_q;
   logic [CFG_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (en_we) en_q <= en_wd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_we) cfg_q <= cfg_wd;
   end

   assign en_o  = en_q;
   assign cfg_o = cfg_q;
endmodule

// File: rtl/cev_route.sv
module cev_route
   import cev_pkg::*;
#(
   parameter int unsigned CFG_W      = 10,
   parameter int unsigned DMA_EN_LSB = 5,
   parameter int unsigned REMAP_BIT  = 9
) (
   input  src_vec_t         status_i,
   input  src_vec_t         en_i,
   input  logic [CFG_W-1:0] cfg_i,
   output src_vec_t         pend_o,
   output src_vec_t         dma_o,
   output logic             rdy_ctx_o,
   output logic             rdy_save_o,
   output logic             rdy_in_o,
   output logic             rdy_out_o
);
   src_vec_t dma_en;
   logic     remap;
   src_vec_t eff;   // status after optional folding of context-out
   logic     unused_cfg;

   assign remap = cfg_i[REMAP_BIT];
   assign dma_en[SRC_CTX_IN]   = cfg_i[DMA_EN_LSB + DMA_OFS_CTX_IN];
   assign dma_en[SRC_DATA_IN]  = cfg_i[DMA_EN_LSB + DMA_OFS_DIN];
   assign dma_en[SRC_DATA_OUT] = cfg_i[DMA_EN_LSB + DMA_OFS_DOUT];
   assign dma_en[SRC_CTX_OUT]  = cfg_i[DMA_EN_LSB + DMA_OFS_CTX_OUT];
   assign unused_cfg = ^cfg_i;

   always_comb begin
      eff = status_i;
      if (remap) begin
         eff[SRC_DATA_OUT] = status_i[SRC_DATA_OUT] | status_i[SRC_CTX_OUT];
         eff[SRC_CTX_OUT]  = 1'b0;
      end
   end

   assign pend_o = eff & en_i;
   assign dma_o  = eff & dma_en;

   assign rdy_save_o = status_i[SRC_CTX_OUT];
   assign rdy_ctx_o  = status_i[SRC_CTX_IN] & ~status_i[SRC_CTX_OUT];
   assign rdy_in_o   = status_i[SRC_DATA_IN];
   assign rdy_out_o  = status_i[SRC_DATA_OUT];
endmodule

// File: rtl/cev_irq_out.sv
module cev_irq_out #(
   parameter int unsigned NSRC    = 4,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] pend_i,
   output logic            irq_o
);
   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |pend_i;
         end
         assign irq_o = irq_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq_o = |pend_i;
      end
   endgenerate
endmodule

// File: rtl/cryp_evt_ctrl.sv
module cryp_evt_ctrl
   import cev_pkg::*;
#(
   parameter int unsigned CFG_W      = 10,
   parameter int unsigned DMA_EN_LSB = 5,
   parameter int unsigned REMAP_BIT  = 9,
   parameter bit          SET_WINS   = 1'b1,
   parameter bit          IRQ_REG    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 evt_ctx_in,
   input  logic                 evt_din,
   input  logic                 evt_dout,
   input  logic                 evt_ctx_out,
   input  logic                 save_ctx,
   input  logic                 svc_ctx_wr,
   input  logic                 svc_din_wr,
   input  logic                 svc_dout_rd,
   input  logic                 svc_tag_rd,
   input  logic                 irq_en_we,
   input  logic [NUM_SRC-1:0]   irq_en_wd,
   input  logic                 cfg_we,
   input  logic [CFG_W-1:0]     cfg_wd,
   output logic [NUM_SRC-1:0]   irq_status,
   output logic                 irq,
   output logic [NUM_SRC-1:0]   dma_req,
   output logic                 rdy_ctx,
   output logic                 rdy_save,
   output logic                 rdy_in,
   output logic                 rdy_out,
   output logic                 reset_done
);
   localparam int unsigned DMA_EN_MSB = DMA_EN_LSB + NUM_SRC - 1;

   initial begin
      assert (CFG_W > REMAP_BIT)
         else $fatal(1, "configuration word too narrow for remap bit");
      assert (DMA_EN_MSB < CFG_W)
         else $fatal(1, "DMA enable field exceeds configuration word");
      assert (REMAP_BIT > DMA_EN_MSB || REMAP_BIT < DMA_EN_LSB)
         else $fatal(1, "remap bit overlaps DMA enable field");
   end

   src_vec_t         set_v, clr_v, status, en_q, pend;
   logic [CFG_W-1:0] cfg_q;
   logic             done_q;

   assign set_v[SRC_CTX_IN]   = evt_ctx_in;
   assign set_v[SRC_DATA_IN]  = evt_din;
   assign set_v[SRC_DATA_OUT] = evt_dout;
   assign set_v[SRC_CTX_OUT]  = evt_ctx_out & save_ctx;

   assign clr_v[SRC_CTX_IN]   = svc_ctx_wr;
   assign clr_v[SRC_DATA_IN]  = svc_din_wr;
   assign clr_v[SRC_DATA_OUT] = svc_dout_rd;
   assign clr_v[SRC_CTX_OUT]  = svc_tag_rd;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      cev_flag #(.SET_WINS(SET_WINS)) u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_v[i]),
         .clr_i  (clr_v[i]),
         .flag_o (status[i])
      );
   end

   cev_regs #(.NSRC(NUM_SRC), .CFG_W(CFG_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_we  (irq_en_we),
      .en_wd  (irq_en_wd),
      .cfg_we (cfg_we),
      .cfg_wd (cfg_wd),
      .en_o   (en_q),
      .cfg_o  (cfg_q)
   );

   cev_route #(
      .CFG_W(CFG_W), .DMA_EN_LSB(DMA_EN_LSB), .REMAP_BIT(REMAP_BIT)
   ) u_route (
      .status_i   (status),
      .en_i       (en_q),
      .cfg_i      (cfg_q),
      .pend_o     (pend),
      .dma_o      (dma_req),
      .rdy_ctx_o  (rdy_ctx),
      .rdy_save_o (rdy_save),
      .rdy_in_o   (rdy_in),
      .rdy_out_o  (rdy_out)
   );

   cev_irq_out #(.NSRC(NUM_SRC), .IRQ_REG(IRQ_REG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (pend),
      .irq_o  (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= 1'b1;
   end

   assign reset_done = done_q;
   assign irq_status = status;
endmodule

// File: rtl/cev_chk.sv
module cev_chk #(
   parameter int unsigned CFG_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             evt_din,
   input logic             evt_ctx_out,
   input logic             save_ctx,
   input logic [3:0]       irq_status,
   input logic [3:0]       en_q,
   input logic [CFG_W-1:0] cfg_q,
   input logic             irq,
   input logic [3:0]       dma_req,
   input logic             rdy_ctx,
   input logic             rdy_save,
   input logic             reset_done
);
   // R1
   a_r1_done_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> reset_done);
   // R2
   a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      evt_din |=> irq_status[1]);
   // R3
   a_r3_no_save_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_status[3] && !(evt_ctx_out && save_ctx)) |=> !irq_status[3]);
   // R4
   a_r4_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (|(irq_status[2:0] & en_q[2:0])) |=> irq);
   // R6
   a_r6_dma_din_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[5] |-> !dma_req[1]);
   // R7
   a_r7_remap_blocks_ctx: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[9] |-> !dma_req[3]);
   // R8
   a_r8_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rdy_ctx && rdy_save));
endmodule

bind cryp_evt_ctrl cev_chk #(.CFG_W(CFG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_din     (evt_din),
   .evt_ctx_out (evt_ctx_out),
   .save_ctx    (save_ctx),
   .irq_status  (irq_status),
   .en_q        (en_q),
   .cfg_q       (cfg_q),
   .irq         (irq),
   .dma_req     (dma_req),
   .rdy_ctx     (rdy_ctx),
   .rdy_save    (rdy_save),
   .reset_done  (reset_done)
);

// File: tb/cryp_evt_ctrl_test.sv
module cryp_evt_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ev = '0;   // ctx_in, din, dout, ctx_out in status order
   logic [3:0] sv = '0;   // ctx_wr, din_wr, dout_rd, tag_rd
   logic       save_ctx = 1'b0;
   logic       irq_en_we = 1'b0;
   logic [3:0] irq_en_wd = '0;
   logic       cfg_we = 1'b0;
   logic [9:0] cfg_wd = '0;
   logic [3:0] irq_status, dma_req;
   logic       irq, rdy_ctx, rdy_save, rdy_in, rdy_out, reset_done;
   int         n_run = 0;
   int         n_bad = 0;

   always #10 clk = ~clk;

   cryp_evt_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .evt_ctx_in(ev[0]), .evt_din(ev[1]), .evt_dout(ev[2]), .evt_ctx_out(ev[3]),
      .save_ctx(save_ctx),
      .svc_ctx_wr(sv[0]), .svc_din_wr(sv[1]), .svc_dout_rd(sv[2]), .svc_tag_rd(sv[3]),
      .irq_en_we(irq_en_we), .irq_en_wd(irq_en_wd),
      .cfg_we(cfg_we), .cfg_wd(cfg_wd),
      .irq_status(irq_status), .irq(irq), .dma_req(dma_req),
      .rdy_ctx(rdy_ctx), .rdy_save(rdy_save), .rdy_in(rdy_in), .rdy_out(rdy_out),
      .reset_done(reset_done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse(input logic [3:0] e, input logic [3:0] s);
      ev = e; sv = s;
      step();
      ev = '0; sv = '0;
   endtask

   task automatic wr_en(input logic [3:0] v);
      irq_en_we = 1'b1; irq_en_wd = v;
      step();
      irq_en_we = 1'b0;
   endtask

   task automatic wr_cfg(input logic [9:0] v);
      cfg_we = 1'b1; cfg_wd = v;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 status", irq_status, 4'h0);
      chk("R1 irq", irq, 1'b0);
      chk("R1 dma", dma_req, 4'h0);
      chk("R1 done low", reset_done, 1'b0);
      rst_n = 1'b1;
      #1 chk("R1 done before edge", reset_done, 1'b0);
      step();
      chk("R1 done", reset_done, 1'b1);
   endtask

   task automatic t_set_clear();
      pulse(4'b0010, 4'b0000);
      chk("R2 din set", irq_status, 4'b0010);
      chk("R9 rdy_in", rdy_in, 1'b1);
      pulse(4'b0000, 4'b0010);
      chk("R2 din clear", irq_status, 4'b0000);
      pulse(4'b0100, 4'b0000);
      chk("R2 dout set", irq_status, 4'b0100);
      chk("R9 rdy_out", rdy_out, 1'b1);
      pulse(4'b0000, 4'b0100);
      chk("R2 dout clear", irq_status, 4'b0000);
      pulse(4'b0010, 4'b0010);
      chk("R2 set wins collision", irq_status, 4'b0010);
      chk("R9 rdy_in after collision", rdy_in, 1'b1);
      pulse(4'b0000, 4'b0010);
   endtask

   task automatic t_save();
      save_ctx = 1'b0;
      pulse(4'b1000, 4'b0000);
      chk("R3 no save no flag", irq_status, 4'b0000);
      save_ctx = 1'b1;
      pulse(4'b1000, 4'b0000);
      chk("R3 save flag", irq_status, 4'b1000);
      chk("R8 rdy_save", rdy_save, 1'b1);
      pulse(4'b0001, 4'b0000);
      chk("R8 ctx masked", {rdy_ctx, rdy_save}, 2'b01);
      pulse(4'b0000, 4'b1000);
      chk("R8 ctx after tag read", {rdy_ctx, rdy_save}, 2'b10);
      pulse(4'b0000, 4'b0001);
      chk("R2 ctx clear", irq_status, 4'b0000);
   endtask

   task automatic t_irq();
      pulse(4'b0010, 4'b0000);
      step();
      chk("R5 disabled no irq", irq, 1'b0);
      irq_en_we = 1'b1; irq_en_wd = 4'b0010;
      step();
      irq_en_we = 1'b0;
      chk("R4 irq one edge later", irq, 1'b0);
      step();
      chk("R4 irq high", irq, 1'b1);
      pulse(4'b0000, 4'b0010);
      chk("R4 irq still registered", irq, 1'b1);
      step();
      chk("R4 irq falls", irq, 1'b0);
      wr_en(4'b0000);
   endtask

   task automatic t_dma();
      save_ctx = 1'b1;
      pulse(4'b1111, 4'b0000);
      wr_cfg(10'h020); chk("R6 bit5 din", dma_req, 4'b0010);
      wr_cfg(10'h040); chk("R6 bit6 dout", dma_req, 4'b0100);
      wr_cfg(10'h080); chk("R6 bit7 ctx_in", dma_req, 4'b0001);
      wr_cfg(10'h100); chk("R6 bit8 ctx_out", dma_req, 4'b1000);
      wr_cfg(10'h000); chk("R6 none", dma_req, 4'b0000);
      pulse(4'b0000, 4'b1111);
   endtask

   task automatic t_remap();
      save_ctx = 1'b1;
      pulse(4'b1000, 4'b0000);
      wr_cfg(10'h340);
      chk("R7 ctx_out on dout dma", dma_req, 4'b0100);
      wr_cfg(10'h300);
      chk("R7 ctx_out enable ignored", dma_req, 4'b0000);
      wr_en(4'b1000);
      step();
      chk("R7 ctx_out irq enable ignored", irq, 1'b0);
      wr_en(4'b0100);
      step();
      chk("R7 ctx_out irq via dout", irq, 1'b1);
      wr_cfg(10'h100);
      chk("R6 unmapped ctx_out dma", dma_req, 4'b1000);
      wr_en(4'b0000);
      pulse(4'b0000, 4'b1000);
      wr_cfg(10'h000);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_run++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_set_clear();
      t_save();
      t_irq();
      t_dma();
      t_remap();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule